// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator as two 32-bit halves and updates it from a stream of single-cycle commands. Each command comes with two signed 32-bit operands. It can add the operand product to the accumulator, subtract the product from it, or return the accumulator's low half while clearing the whole accumulator in the same step. The product is cut to its low 32 bits and then sign-extended before it reaches the accumulator, so a product that does not fit in 32 bits adds only its wrapped 32-bit value. Accumulator arithmetic wraps modulo 2^64 and raises no flag.

A host sends at most one command per cycle by raising `op_valid` together with `op_code` and the operands. Every command finishes in the cycle in which it is accepted, so a read-and-clear may follow a multiply command directly and needs no stall. Both halves of the accumulator are always visible on `acc_hi` and `acc_lo`. A small controller has two states. `ST_ZERO` means the accumulator is known to be zero and is the state after reset. `ST_LIVE` means it may hold a non-zero value. A multiply-add or multiply-subtract moves the controller from `ST_ZERO` to `ST_LIVE`, and a read-and-clear moves it from `ST_LIVE` back to `ST_ZERO`. Every other command keeps the current state.

Top module: `mac_acc_unit`

## Requirements
- R1: While `rst_n` is low, both accumulator halves, `rd_valid` and `rd_data` are zero.
- R2: A command with `op_code` 2'b00 (multiply-add) adds the sign-extended low 32 bits of `opnd_a*opnd_b` to the 64-bit value {`acc_hi`,`acc_lo`}.
- R3: A command with `op_code` 2'b01 (multiply-subtract) subtracts the sign-extended low 32 bits of `opnd_a*opnd_b` from {`acc_hi`,`acc_lo`}.
- R4: A command with `op_code` 2'b10 (read-and-clear) puts the accumulator's low half on `rd_data` and sets `rd_valid` for one cycle. In the same step it zeroes both halves.
- R5: The effect of every command appears on the outputs in the cycle after the clock edge that accepts it. Commands on consecutive cycles are each applied, in order.
- R6: When `op_valid` is low, the accumulator, `rd_valid` and `rd_data` do not change.
- R7: The code 2'b11 is reserved. A command with this code leaves the accumulator unchanged and does not raise `rd_valid`.
- R8: A product that does not fit in 32 bits contributes only its low 32 bits, taken as signed. For example, 0x10000*0x10000 adds 0, and 0x8000*0x10000 adds -2^31.
- R9: Accumulator arithmetic wraps modulo 2^64. For example, zero minus one gives all ones, and adding one to all ones gives zero.
- R10: `rd_data` keeps the last value read until the next read-and-clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Command strobe |
| op_code | input | 2 | 00 multiply-add, 01 multiply-subtract, 10 read-and-clear, 11 reserved |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| rd_valid | output | 1 | One-cycle pulse after a read-and-clear |
| rd_data | output | 32 | Low half returned by the last read-and-clear |
| acc_hi | output | 32 | Upper accumulator half |
| acc_lo | output | 32 | Lower accumulator half |

## Verification
Every result is due one cycle after its command. The accumulator halves, `rd_valid` and `rd_data` all change at the clock edge that accepts the command, and nothing is updated later than that. The driver applies each command at a falling edge and pushes the expected outputs for that cycle into a queue. The monitor pops one item just after each rising edge and compares it, so every check lands in the cycle right after the accepting edge. Idle cycles and reserved-code cycles also push an expectation, so the check that nothing changed is made at the ports.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int unsigned HALF_W = 32;
    localparam int unsigned ACC_W  = 2 * HALF_W;
    localparam int unsigned CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        MAC_OP_ADD   = 2'b00,
        MAC_OP_SUB   = 2'b01,
        MAC_OP_RDCLR = 2'b10,
        MAC_OP_RSVD  = 2'b11
    } mac_op_e;

    typedef enum logic {
        ST_ZERO = 1'b0,
        ST_LIVE = 1'b1
    } mac_state_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   fac_a,
    input  logic [W-1:0]   fac_b,
    output logic [2*W-1:0] addend
);
    // The low W bits of a product do not depend on signedness.
    logic [W-1:0] prod_lo;

    assign prod_lo = fac_a * fac_b;
    assign addend  = {{W{prod_lo[W-1]}}, prod_lo};
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_add,
    input  logic         do_sub,
    input  logic         do_clr,
    input  logic [2*W-1:0] addend,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);
    localparam int unsigned AW = 2 * W;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_d;

    always_comb begin
        acc_d = acc_q;
        if (do_clr) begin
            acc_d = '0;
        end else if (do_add) begin
            acc_d = acc_q + addend;
        end else if (do_sub) begin
            acc_d = acc_q - addend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign hi_q = acc_q[AW-1:W];
    assign lo_q = acc_q[W-1:0];
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [CODE_W-1:0] op_code,
    input  logic [W-1:0]      lo_now,
    output logic              do_add,
    output logic              do_sub,
    output logic              do_clr,
    output logic              rd_valid,
    output logic [W-1:0]      rd_data
);
    mac_state_e state_q;
    mac_state_e state_d;
    mac_op_e    op;

    assign op = mac_op_e'(op_code);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and command decode
    always_comb begin
        state_d = state_q;
        do_add  = 1'b0;
        do_sub  = 1'b0;
        do_clr  = 1'b0;
        if (op_valid) begin
            unique case (op)
                MAC_OP_ADD:   do_add = 1'b1;
                MAC_OP_SUB:   do_sub = 1'b1;
                MAC_OP_RDCLR: do_clr = 1'b1;
                MAC_OP_RSVD:  ;
            endcase
        end
        unique case (state_q)
            ST_ZERO: if (do_add || do_sub) state_d = ST_LIVE;
            ST_LIVE: if (do_clr)           state_d = ST_ZERO;
        endcase
    end

    // Read-back outputs; in ST_ZERO the low half is known to be zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= do_clr;
            if (do_clr) begin
                rd_data <= (state_q == ST_LIVE) ? lo_now : '0;
            end
        end
    end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [CODE_W-1:0] op_code,
    input  logic [HALF_W-1:0] opnd_a,
    input  logic [HALF_W-1:0] opnd_b,
    output logic              rd_valid,
    output logic [HALF_W-1:0] rd_data,
    output logic [HALF_W-1:0] acc_hi,
    output logic [HALF_W-1:0] acc_lo
);
    logic             do_add;
    logic             do_sub;
    logic             do_clr;
    logic [ACC_W-1:0] addend;

    mac_product #(.W(HALF_W)) u_prod (
        .fac_a  (opnd_a),
        .fac_b  (opnd_b),
        .addend (addend)
    );

    mac_ctrl #(.W(HALF_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .lo_now   (acc_lo),
        .do_add   (do_add),
        .do_sub   (do_sub),
        .do_clr   (do_clr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    mac_accum #(.W(HALF_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_add (do_add),
        .do_sub (do_sub),
        .do_clr (do_clr),
        .addend (addend),
        .hi_q   (acc_hi),
        .lo_q   (acc_lo)
    );
endmodule

// File: rtl/mac_acc_unit_chk.sv
module mac_acc_unit_chk
    import mac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [CODE_W-1:0] op_code,
    input logic [HALF_W-1:0] opnd_a,
    input logic [HALF_W-1:0] opnd_b,
    input logic              rd_valid,
    input logic [HALF_W-1:0] rd_data,
    input logic [HALF_W-1:0] acc_hi,
    input logic [HALF_W-1:0] acc_lo
);
    logic [HALF_W-1:0] p_lo;
    logic [ACC_W-1:0]  p_ext;
    logic [ACC_W-1:0]  acc;
    logic              is_add, is_sub, is_rd, is_rsv;

    assign p_lo   = opnd_a * opnd_b;
    assign p_ext  = {{HALF_W{p_lo[HALF_W-1]}}, p_lo};
    assign acc    = {acc_hi, acc_lo};
    assign is_add = op_valid && (op_code == 2'b00);
    assign is_sub = op_valid && (op_code == 2'b01);
    assign is_rd  = op_valid && (op_code == 2'b10);
    assign is_rsv = op_valid && (op_code == 2'b11);

    AST_MADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        is_add |=> acc == $past(acc) + $past(p_ext)); // R2
    AST_MSUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        is_sub |=> acc == $past(acc) - $past(p_ext)); // R3
    AST_RDCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> (acc == '0) && rd_valid && (rd_data == $past(acc_lo))); // R4
    AST_RDVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(is_rd)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc) && $stable(rd_data) && !rd_valid); // R6
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        is_rsv |=> $stable(acc) && !rd_valid); // R7
    AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> $stable(rd_data)); // R10
endmodule

bind mac_acc_unit mac_acc_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo)
);

// File: tb/mac_acc_unit_tb.sv
module mac_acc_unit_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] acc;
        logic        rv;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    exp_t        sb_q[$];
    logic [63:0] m_acc = '0;
    logic [31:0] m_rd  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_acc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .rd_valid(rd_valid),
        .rd_data(rd_data), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    // Driver: one command per call, expectation pushed for the next edge
    task automatic step(input logic v, input logic [1:0] c,
                        input logic [31:0] a, input logic [31:0] b,
                        input string tag);
        logic [31:0] p;
        logic [63:0] ext;
        exp_t e;
        @(negedge clk);
        op_valid = v; op_code = c; opnd_a = a; opnd_b = b;
        p   = a * b;
        ext = {{32{p[31]}}, p};
        e.rv = 1'b0;
        if (v && c == 2'b00) m_acc = m_acc + ext;
        else if (v && c == 2'b01) m_acc = m_acc - ext;
        else if (v && c == 2'b10) begin
            m_rd = m_acc[31:0];
            m_acc = '0;
            e.rv = 1'b1;
        end
        e.acc = m_acc; e.rd = m_rd; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if ({acc_hi, acc_lo} !== e.acc || rd_valid !== e.rv || rd_data !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: acc=%h rv=%b rd=%h expected acc=%h rv=%b rd=%h",
                             e.tag, {acc_hi, acc_lo}, rd_valid, rd_data, e.acc, e.rv, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a command presented that must be ignored
        op_valid = 1'b1; op_code = 2'b00; opnd_a = 32'd5; opnd_b = 32'd7;
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if ({acc_hi, acc_lo} !== 64'd0 || rd_valid !== 1'b0 || rd_data !== 32'd0) begin
            n_fail++;
            $display("FAIL R1: acc=%h rv=%b rd=%h expected all zero",
                     {acc_hi, acc_lo}, rd_valid, rd_data);
        end
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b1;

        step(1, 2'b00, 32'd3, 32'd4, "R2");
        step(1, 2'b00, 32'hFFFF_FFFE, 32'd5, "R2");
        step(1, 2'b01, 32'd6, 32'hFFFF_FFFD, "R3");
        step(1, 2'b10, 32'd0, 32'd0, "R4");
        step(0, 2'b00, 32'd9, 32'd9, "R6");
        step(0, 2'b10, 32'd1, 32'd1, "R6");
        step(0, 2'b00, 32'd0, 32'd0, "R10");
        step(1, 2'b00, 32'h0001_0000, 32'h0001_0000, "R8");
        step(1, 2'b00, 32'h0000_8000, 32'h0001_0000, "R8");
        step(1, 2'b11, 32'd100, 32'd100, "R7");
        step(1, 2'b10, 32'd0, 32'd0, "R4");
        step(1, 2'b01, 32'd1, 32'd1, "R9");
        step(1, 2'b00, 32'd1, 32'd1, "R9");
        for (int i = 0; i < 4; i++)
            step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, "R5");
        step(1, 2'b01, 32'h1234_5678, 32'd3, "R5");
        step(1, 2'b10, 32'd0, 32'd0, "R5");
        step(1, 2'b00, 32'd11, 32'd13, "R5");
        step(1, 2'b10, 32'd0, 32'd0, "R4");
        step(1, 2'b10, 32'd0, 32'd0, "R4");
        step(0, 2'b00, 32'd0, 32'd0, "R10");
        step(0, 2'b00, 32'd0, 32'd0, "R6");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule